// File: doc/BRIEF.md
# CAS-before-RAS Refresh Injector

This block sits between an existing memory timing generator and a bank of asynchronous DRAM. The generator already issues refresh slots, but it gives RAS-only refresh, which relies on the DRAM seeing a row address. Those row addresses do not cover every row of larger devices. The injector turns each of those slots into a CAS-before-RAS cycle. In that cycle the DRAM ignores the address pins and refreshes the row named by its own internal counter, which it then advances by one.

The block runs on a fast sample clock that cuts every processor bus cycle into equal ticks. It samples five inputs on each tick: the bank CAS and RAS strobes, the refresh request, the phase-2 clock and a delayed phase tap. It then drives the CAS pin of the DRAM from a register.

When no refresh is requested, the bank CAS passes straight through. During a refresh request, CAS is driven low only where phase-2 and the delayed tap are both low. This gives the order CAS falls, RAS falls, CAS rises, RAS rises. Any CAS still held low from the previous access is forced high, so it cannot turn into a hidden refresh.

A built-in checker counts completed refreshes. It flags a wrong strobe order, a short CAS-to-RAS precharge gap, and a refresh budget window that ends with too few refreshes. All flags are sticky until reset.

Top module: `rfi_cbr_injector`

## Requirements
- R1: While reset is asserted and on the first tick after it is released, `dram_cas_n` is 1, `refresh_count` is 0, and `order_err`, `precharge_err` and `starve_err` are 0.
- R2: When `refresh_n` is 1 on a tick, `dram_cas_n` after that tick's clock edge equals the `bank_cas_n` sampled on that edge.
- R3: When `refresh_n` is 0 on a tick, `dram_cas_n` after that edge is 0 if `phi2` and `phase_tap_n` were both 0, and 1 otherwise, whatever `bank_cas_n` is. A CAS still low from a previous access is therefore forced high.
- R4: A refresh is armed when `bank_ras_n` is seen falling (1 on the previous tick, 0 on this one) while `refresh_n` is 0 and `dram_cas_n` is 0. The next rise of `bank_ras_n` completes it, and `refresh_count` increases by one if `dram_cas_n` is 1 at that moment. No other event changes the count, and the count wraps at 2^CNT_W.
- R5: `order_err` is set when `bank_ras_n` falls while `refresh_n` is 0 and `dram_cas_n` is 1. It is also set when an armed refresh sees `bank_ras_n` rise while `dram_cas_n` is still 0.
- R6: `precharge_err` is set when `bank_ras_n` is first sampled low at most GAP ticks after the edge on which `dram_cas_n` went high, while `dram_cas_n` is still high.
- R7: The ticks after reset are split into windows of BUDGET ticks. On the last tick of a window, `starve_err` is set if fewer than ROWS refreshes completed inside that window.
- R8: Every error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one tick per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_cas_n | input | 1 | Bank CAS from the timing generator, active low |
| bank_ras_n | input | 1 | Bank RAS from the timing generator, active low |
| refresh_n | input | 1 | Refresh slot request, active low |
| phi2 | input | 1 | Processor phase-2 clock |
| phase_tap_n | input | 1 | Delayed phase tap, low in the middle of the bus cycle |
| dram_cas_n | output | 1 | Registered CAS to the DRAM, active low |
| refresh_count | output | CNT_W | Completed CAS-before-RAS refreshes, wrapping |
| order_err | output | 1 | Sticky strobe-order violation |
| precharge_err | output | 1 | Sticky CAS-to-RAS precharge violation |
| starve_err | output | 1 | Sticky refresh-budget shortfall |

## Verification
The bench targets a refresh slot that opens while the previous access still holds CAS low. A design that merely gated the request into CAS would carry that low level into the slot, and the scoreboard would catch the mismatch on those ticks.

It probes the precharge gap at both sides of the limit, at GAP+1 ticks and at exactly GAP ticks. An off-by-one compare would either flag the legal case or miss the illegal one.

It also drives a slot in which RAS falls before the CAS window opens. That slot must raise `order_err` and leave the count unchanged, and only reset may clear the flag.

Budget windows are run both with too few refreshes and with enough of them, so the starvation flag has to depend on the count and not on elapsed time alone.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

  typedef struct packed {
    logic fall;
    logic rise;
  } strobe_edge_t;

  // Edge decode of an active-low strobe between two consecutive samples.
  function automatic strobe_edge_t strobe_edges(input logic prev_n, input logic cur_n);
    strobe_edge_t e;
    e.fall = prev_n & ~cur_n;
    e.rise = ~prev_n & cur_n;
    return e;
  endfunction

endpackage

// File: rtl/rfi_cas_gate.sv
module rfi_cas_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_cas_n,
  input  logic refresh_n,
  input  logic phi2,
  input  logic phase_tap_n,
  output logic cas_n
);

  logic in_window;
  logic cas_nxt;

  // The overlap of request, phase-2 low and tap low gives the CAS window.
  assign in_window = ~refresh_n & ~phi2 & ~phase_tap_n;
  assign cas_nxt   = refresh_n ? bank_cas_n : ~in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cas_n <= 1'b1;
    else        cas_n <= cas_nxt;
  end

  p_pass_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_n |=> (cas_n == $past(bank_cas_n)));

  p_stale_cas_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_n && !bank_cas_n && (phi2 || phase_tap_n)) |=> cas_n);

endmodule

// File: rtl/rfi_ref_tracker.sv
module rfi_ref_tracker
  import rfi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_edge_t     ras_e,
  input  logic             refresh_n,
  input  logic             cas_n,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             order_err
);

  logic armed;
  logic arm_now;
  logic early_ras;
  logic late_cas;

  assign arm_now   = ras_e.fall & ~refresh_n & ~cas_n;
  assign early_ras = ras_e.fall & ~refresh_n & cas_n;
  assign done      = ras_e.rise & armed & cas_n;
  assign late_cas  = ras_e.rise & armed & ~cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      count     <= '0;
      order_err <= 1'b0;
    end else begin
      if (arm_now)        armed <= 1'b1;
      else if (ras_e.rise) armed <= 1'b0;
      if (done)           count <= count + 1'b1;
      if (early_ras || late_cas) order_err <= 1'b1;
    end
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == CNT_W'($past(count) + 1'b1)));

  p_no_count_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_e.rise && !armed) |=> (count == $past(count)));

  p_order_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);

endmodule

// File: rtl/rfi_timing_checker.sv
module rfi_timing_checker #(
  parameter int GAP    = 2,
  parameter int ROWS   = 512,
  parameter int BUDGET = 457143
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_fall,
  input  logic cas_n,
  input  logic done,
  output logic precharge_err,
  output logic starve_err
);

  localparam int AGE_W = $clog2(GAP + 1);
  localparam int TW    = $clog2(BUDGET);
  localparam int RW    = $clog2(ROWS + 1);

  logic [AGE_W-1:0] age;
  logic [TW-1:0]    tick;
  logic [RW-1:0]    win, win_nxt;
  logic             at_end;
  logic             short_gap;

  assign short_gap = ras_fall & cas_n & (age < AGE_W'(GAP));
  assign at_end    = (tick == TW'(BUDGET - 1));
  assign win_nxt   = (done && (win < RW'(ROWS))) ? win + 1'b1 : win;

  // Ticks since CAS went high, saturating at GAP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   age <= AGE_W'(GAP);
    else if (!cas_n)              age <= '0;
    else if (age < AGE_W'(GAP))   age <= age + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick          <= '0;
      win           <= '0;
      starve_err    <= 1'b0;
      precharge_err <= 1'b0;
    end else begin
      if (short_gap) precharge_err <= 1'b1;
      if (at_end) begin
        tick <= '0;
        win  <= '0;
        if (win_nxt < RW'(ROWS)) starve_err <= 1'b1;
      end else begin
        tick <= tick + 1'b1;
        win  <= win_nxt;
      end
    end
  end

  p_starve_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(starve_err) |-> $past(at_end));

  p_precharge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    precharge_err |=> precharge_err);

  p_starve_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    starve_err |=> starve_err);

endmodule

// File: rtl/rfi_cbr_injector.sv
module rfi_cbr_injector
  import rfi_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GAP    = 2,
  parameter int ROWS   = 512,
  parameter int BUDGET = 457143
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_cas_n,
  input  logic             bank_ras_n,
  input  logic             refresh_n,
  input  logic             phi2,
  input  logic             phase_tap_n,
  output logic             dram_cas_n,
  output logic [CNT_W-1:0] refresh_count,
  output logic             order_err,
  output logic             precharge_err,
  output logic             starve_err
);

  logic         ras_q;
  logic         done;
  strobe_edge_t ras_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_q <= 1'b1;
    else        ras_q <= bank_ras_n;
  end

  assign ras_e = strobe_edges(ras_q, bank_ras_n);

  rfi_cas_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_cas_n  (bank_cas_n),
    .refresh_n   (refresh_n),
    .phi2        (phi2),
    .phase_tap_n (phase_tap_n),
    .cas_n       (dram_cas_n)
  );

  rfi_ref_tracker #(.CNT_W(CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_e     (ras_e),
    .refresh_n (refresh_n),
    .cas_n     (dram_cas_n),
    .count     (refresh_count),
    .done      (done),
    .order_err (order_err)
  );

  rfi_timing_checker #(.GAP(GAP), .ROWS(ROWS), .BUDGET(BUDGET)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_fall      (ras_e.fall),
    .cas_n         (dram_cas_n),
    .done          (done),
    .precharge_err (precharge_err),
    .starve_err    (starve_err)
  );

endmodule

// File: tb/tb_rfi_cbr_injector.sv
module tb_rfi_cbr_injector;

  localparam int CNT_W = 8;
  localparam int GAP = 2;
  localparam int ROWS = 2;
  localparam int BUDGET = 640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_cas_n = 1'b1, bank_ras_n = 1'b1, refresh_n = 1'b1;
  logic phi2 = 1'b1, phase_tap_n = 1'b1;
  logic dram_cas_n;
  logic [CNT_W-1:0] refresh_count;
  logic order_err, precharge_err, starve_err;

  int checks = 0;
  int fails = 0;
  int ras_carry = 0, cas_carry = 0, ref_carry = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rfi_cbr_injector #(.CNT_W(CNT_W), .GAP(GAP), .ROWS(ROWS), .BUDGET(BUDGET)) dut (
    .clk(clk), .rst_n(rst_n), .bank_cas_n(bank_cas_n), .bank_ras_n(bank_ras_n),
    .refresh_n(refresh_n), .phi2(phi2), .phase_tap_n(phase_tap_n),
    .dram_cas_n(dram_cas_n), .refresh_count(refresh_count), .order_err(order_err),
    .precharge_err(precharge_err), .starve_err(starve_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard after each clock edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(dram_cas_n), int'(e));
      end
    end
  end

  // Driver: applies one tick and pushes the expected CAS.
  task automatic drive(input logic c, input logic r, input logic rf, input logic p, input logic tp);
    @(negedge clk);
    bank_cas_n = c; bank_ras_n = r; refresh_n = rf; phi2 = p; phase_tap_n = tp;
    if (rf) begin
      exp_q.push_back(c); tag_q.push_back("R2 pass-through");
    end else begin
      exp_q.push_back(!(!p && !tp)); tag_q.push_back("R3 refresh window");
    end
  endtask

  // One bus cycle of 64 ticks; ras_t < 0 or cas_s < 0 means no strobe.
  task automatic bus_cycle(input bit ref_on, input int ras_t, input int cas_s, input int cas_e);
    for (int t = 0; t < 64; t++) begin
      logic p, tp, r, c, rf;
      p  = (t >= 32);
      tp = !(t >= 20 && t < 52);
      r  = !((t < ras_carry) || (ras_t >= 0 && t >= ras_t));
      c  = !((t < cas_carry) || (cas_s >= 0 && t >= cas_s && t < cas_e));
      rf = !((t < ref_carry) || (ref_on && t >= 8));
      drive(c, r, rf, p, tp);
    end
    ras_carry = (ras_t < 0) ? 0 : (ref_on ? 7 : 6);
    cas_carry = (cas_e > 64) ? cas_e - 64 : 0;
    ref_carry = ref_on ? 8 : 0;
  endtask

  task automatic normal();   bus_cycle(1'b0, 30, 40, 76); endtask
  task automatic refresh();  bus_cycle(1'b1, 24, -1, 0);  endtask
  task automatic idle();     bus_cycle(1'b0, -1, -1, 0);  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bank_cas_n = 1'b1; bank_ras_n = 1'b1; refresh_n = 1'b1; phi2 = 1'b1; phase_tap_n = 1'b1;
    ras_carry = 0; cas_carry = 0; ref_carry = 0;
    repeat (3) @(negedge clk);
    check("R1 cas in reset", int'(dram_cas_n), 1);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk); #1;
    check("R1 cas", int'(dram_cas_n), 1);
    check("R1 count", int'(refresh_count), 0);
    check("R1 flags", int'({order_err, precharge_err, starve_err}), 0);

    // R2: plain accesses pass through.
    normal(); normal(); normal();
    // R3/R4: refresh slot opened while the previous CAS is still low.
    refresh(); normal();
    @(negedge clk);
    check("R4 count after one refresh", int'(refresh_count), 1);
    check("R5 no order error", int'(order_err), 0);
    check("R6 no precharge error", int'(precharge_err), 0);
    refresh(); normal();
    @(negedge clk);
    check("R4 count after two refreshes", int'(refresh_count), 2);

    // R6: gap of GAP+1 ticks is legal, gap of GAP ticks is not.
    bus_cycle(1'b0, 54, 40, 51);
    @(negedge clk);
    check("R6 gap GAP+1 legal", int'(precharge_err), 0);
    bus_cycle(1'b0, 53, 40, 51);
    @(negedge clk);
    check("R6 gap GAP flagged", int'(precharge_err), 1);
    normal();
    @(negedge clk);
    check("R8 precharge sticky", int'(precharge_err), 1);

    // R5: RAS falls before the CAS window in a refresh slot.
    bus_cycle(1'b1, 14, -1, 0); normal();
    @(negedge clk);
    check("R5 early RAS flagged", int'(order_err), 1);
    check("R4 early RAS not counted", int'(refresh_count), 2);
    normal();
    @(negedge clk);
    check("R8 order sticky", int'(order_err), 1);

    do_reset();
    @(negedge clk);
    check("R8 reset clears order", int'(order_err), 0);
    check("R8 reset clears precharge", int'(precharge_err), 0);
    check("R1 reset clears count", int'(refresh_count), 0);

    // R7: a window with no refreshes starves.
    for (int i = 0; i < 9; i++) idle();
    check("R7 before window end", int'(starve_err), 0);
    idle(); idle();
    check("R7 starved window", int'(starve_err), 1);

    // R7: a window with enough refreshes does not.
    do_reset();
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) refresh(); else normal();
    end
    @(negedge clk);
    check("R7 fed window", int'(starve_err), 0);
    check("R4 count in fed run", int'(refresh_count), 4);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule